// File: doc/BRIEF.md
# Capture Edge Confirmation Filter

This block sits in front of a timer's capture logic and keeps short glitches on a capture pin from being recorded. The raw pin first passes through a two-flop synchronizer. A separate input selects which transitions count as events: rising, falling, both, or none. When an enabled transition appears, the block notes the synchronized level from just before it and starts a delay of a programmable number of clock cycles. When the delay runs out, the block samples the input once. It emits a single-cycle capture pulse only if the input now sits at the level opposite to the one it noted.

The block does not debounce continuously and does not require the input to stay stable. It makes one comparison at the end of the delay. A 2-bit delay select register can be written and read at any time. Its zero setting bypasses the filter, so that every enabled transition produces a pulse straight away. The block assumes that events are spaced further apart than the chosen delay. Transitions that arrive while a delay is running are dropped.

Top module: `capture_edge_confirm`

## Requirements
- R1: After reset, `cap_pulse` is 0 and `dly_rd_data` reads 2'b00.
- R2: The delay select gives the wait length N: 2'b00 means bypass (no wait), 2'b01 means N = DELAY_UNIT (256), 2'b10 means N = 2*DELAY_UNIT (512) and 2'b11 means N = 4*DELAY_UNIT (1024) clock cycles.
- R3: `edge_sel` decides which synchronized transitions are events: 2'b01 rising only, 2'b10 falling only, 2'b11 both directions, 2'b00 none.
- R4: In bypass, an event yields a one-cycle `cap_pulse` that is high in the cycle after the third rising clock edge following the raw input change. No level check is made.
- R5: With a nonzero delay select, an event yields a one-cycle `cap_pulse` after the (N+3)th rising clock edge following the raw change, and only if the input is still at its new level at that point. A raw change held for N+1 or more cycles produces a pulse. A change that reverts after N or fewer cycles produces none.
- R6: Transitions detected while a delay is running are ignored. The return edge of a suppressed glitch neither restarts the delay nor changes the noted level, so it produces no pulse of its own.
- R7: The delay counter returns to zero when a count ends. An event that arrives after a finished count waits a full N cycles again, so its pulse comes N+3 edges after its own raw change.
- R8: A write of `dly_wr_data` with `dly_wr_en` high is visible on `dly_rd_data` in the next cycle. A write during a running delay cancels that delay, and no pulse is produced for it. An event detected in the same cycle as a write is dropped.
- R9: With `edge_sel` at 2'b00, no `cap_pulse` is produced for any input activity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_raw | input | 1 | Asynchronous capture pin |
| edge_sel | input | 2 | Event edge selection |
| dly_wr_en | input | 1 | Delay select write strobe |
| dly_wr_data | input | 2 | Delay select write value |
| dly_rd_data | output | 2 | Current delay select value |
| cap_pulse | output | 1 | One-cycle confirmed capture pulse |

## Verification
A counter that is off by one, or a level noted on the wrong side of the transition, shows at the port in one of two ways. The pulse moves by a cycle against the N+3 edge mark, or a glitch of exactly N or N+1 cycles flips between pulsed and silent. Both appear within one delay window of the stimulus. A busy flag that fails to clear, or a return edge that is wrongly accepted, shows as an extra pulse or a missing pulse on the next event. Each trial therefore records both the count and the exact cycles of the pulses over a window long enough to cover a second event.

// File: rtl/cec_pkg.sv
package cec_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    typedef enum logic {
        Q_IDLE  = 1'b0,
        Q_COUNT = 1'b1
    } qual_state_e;

    // Synchronized view of the pin
    typedef struct packed {
        logic level;   // current synchronized level
        logic prior;   // level one cycle earlier
        logic rise;
        logic fall;
    } pin_view_t;

    // Wait length in cycles for a delay select code (0 means bypass)
    function automatic int unsigned delay_len(input logic [1:0] sel,
                                              input int unsigned unit);
        int unsigned len;
        case (sel)
            2'b01:   len = unit;
            2'b10:   len = unit * 2;
            2'b11:   len = unit * 4;
            default: len = 0;
        endcase
        return len;
    endfunction

    function automatic logic edge_enabled(input edge_mode_e mode,
                                          input pin_view_t pv);
        return (pv.rise && mode[0]) || (pv.fall && mode[1]);
    endfunction

endpackage

// File: rtl/cec_pin_sync.sv
module cec_pin_sync
    import cec_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_raw,
    output pin_view_t view
);
    localparam int unsigned CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN-2:0], pin_raw};
        end
    end

    always_comb begin
        view.level = chain_q[STAGES-1];
        view.prior = chain_q[STAGES];
        view.rise  = view.level & ~view.prior;
        view.fall  = ~view.level & view.prior;
    end

endmodule

// File: rtl/cec_delay_cfg.sv
module cec_delay_cfg #(
    parameter int unsigned SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_data,
    output logic [SEL_W-1:0] sel
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= '0;
        end else if (wr_en) begin
            sel <= wr_data;
        end
    end

    AST_RD_FOLLOWS_WR: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (sel == $past(wr_data)));  // R8

endmodule

// File: rtl/cec_qualifier.sv
module cec_qualifier
    import cec_pkg::*;
#(
    parameter int unsigned DELAY_UNIT = 256,
    parameter int unsigned MAX_DELAY  = DELAY_UNIT * 4,
    parameter int unsigned CNT_W      = $clog2(MAX_DELAY)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       event_in,
    input  pin_view_t  view,
    input  logic [1:0] dly_sel,
    input  logic       abort,
    output logic       pulse,
    output logic       busy
);
    qual_state_e      state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pre_lvl_q;
    logic [CNT_W-1:0] last_idx;
    logic             bypass;

    always_comb begin
        bypass   = (dly_sel == 2'b00);
        last_idx = CNT_W'(delay_len(dly_sel, DELAY_UNIT) - 1);
        busy     = (state_q == Q_COUNT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= Q_IDLE;
            cnt_q     <= '0;
            pre_lvl_q <= 1'b0;
            pulse     <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (abort) begin
                state_q <= Q_IDLE;
                cnt_q   <= '0;
            end else begin
                case (state_q)
                    Q_IDLE: begin
                        if (event_in) begin
                            if (bypass) begin
                                pulse <= 1'b1;
                            end else begin
                                state_q   <= Q_COUNT;
                                cnt_q     <= '0;
                                pre_lvl_q <= view.prior;
                            end
                        end
                    end
                    Q_COUNT: begin
                        if (cnt_q == last_idx) begin
                            pulse   <= (view.level != pre_lvl_q);
                            state_q <= Q_IDLE;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: state_q <= Q_IDLE;
                endcase
            end
        end
    end

    AST_BYPASS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (dly_sel == 2'b00) |-> !busy);  // R4
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt_q <= last_idx));  // R2
    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (cnt_q == '0));  // R7
    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!busy && !pulse));  // R8
    AST_DELAYED_NEEDS_COUNT: assert property (@(posedge clk) disable iff (rst)
        (pulse && ($past(dly_sel) != 2'b00)) |-> $past(busy));  // R5

endmodule

// File: rtl/capture_edge_confirm.sv
module capture_edge_confirm
    import cec_pkg::*;
#(
    parameter int unsigned DELAY_UNIT  = 256,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_raw,
    input  logic [1:0] edge_sel,
    input  logic       dly_wr_en,
    input  logic [1:0] dly_wr_data,
    output logic [1:0] dly_rd_data,
    output logic       cap_pulse
);
    localparam int unsigned MAX_DELAY = DELAY_UNIT * 4;
    localparam int unsigned CNT_W     = $clog2(MAX_DELAY);

    pin_view_t  view;
    logic [1:0] dly_sel;
    logic       event_in;
    logic       busy;

    cec_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .pin_raw (pin_raw),
        .view    (view)
    );

    cec_delay_cfg #(.SEL_W(2)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (dly_wr_en),
        .wr_data (dly_wr_data),
        .sel     (dly_sel)
    );

    always_comb begin
        event_in = edge_enabled(edge_mode_e'(edge_sel), view);
    end

    cec_qualifier #(
        .DELAY_UNIT (DELAY_UNIT),
        .MAX_DELAY  (MAX_DELAY),
        .CNT_W      (CNT_W)
    ) u_qual (
        .clk      (clk),
        .rst      (rst),
        .event_in (event_in),
        .view     (view),
        .dly_sel  (dly_sel),
        .abort    (dly_wr_en),
        .pulse    (cap_pulse),
        .busy     (busy)
    );

    assign dly_rd_data = dly_sel;

    AST_EDGE_NONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((edge_sel == 2'b00) && !busy) |=> !cap_pulse);  // R9

endmodule

// File: tb/capture_edge_confirm_test.sv
`timescale 1ns/1ps
module capture_edge_confirm_test;
    localparam int unsigned UNIT = 256;

    logic       clk = 1'b0;
    logic       rst;
    logic       pin_raw;
    logic [1:0] edge_sel;
    logic       dly_wr_en;
    logic [1:0] dly_wr_data;
    logic [1:0] dly_rd_data;
    logic       cap_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [1:0] cur_sel = 2'b00;

    always #2 clk = ~clk;

    capture_edge_confirm #(.DELAY_UNIT(UNIT)) uut (
        .clk         (clk),
        .rst         (rst),
        .pin_raw     (pin_raw),
        .edge_sel    (edge_sel),
        .dly_wr_en   (dly_wr_en),
        .dly_wr_data (dly_wr_data),
        .dly_rd_data (dly_rd_data),
        .cap_pulse   (cap_pulse)
    );

    function automatic int wait_len(input logic [1:0] s);
        case (s)
            2'b01:   return UNIT;
            2'b10:   return UNIT * 2;
            2'b11:   return UNIT * 4;
            default: return 0;
        endcase
    endfunction

    function automatic bit valid_edge(input logic [1:0] mode, input logic to_lvl);
        return to_lvl ? mode[0] : mode[1];
    endfunction

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic write_sel(input logic [1:0] v);
        @(negedge clk);
        dly_wr_en   = 1'b1;
        dly_wr_data = v;
        @(negedge clk);
        dly_wr_en = 1'b0;
        cur_sel   = v;
        check("R8", int'(dly_rd_data), int'(v), "delay select readback");
    endtask

    // One event: raw flips after edge 0, returns after edge w (w == 0: never).
    task automatic run_trial(input logic [1:0] mode, input int w, input string req);
        int n;
        logic start;
        int exp_t[2];
        int exp_cnt;
        int got_t[4];
        int got_cnt;
        int span;
        bit v1;
        bit v2;
        n     = wait_len(cur_sel);
        start = pin_raw;
        v1    = valid_edge(mode, ~start);
        v2    = (w > 0) && valid_edge(mode, start);
        exp_cnt = 0;
        if (n == 0) begin
            if (v1) begin exp_t[exp_cnt] = 3; exp_cnt++; end
            if (v2) begin exp_t[exp_cnt] = w + 3; exp_cnt++; end
        end else if (v1) begin
            if (w == 0 || w > n) begin
                exp_t[exp_cnt] = n + 3; exp_cnt++;
                if (v2) begin exp_t[exp_cnt] = w + 3 + n; exp_cnt++; end
            end
        end else if (v2) begin
            exp_t[exp_cnt] = w + 3 + n; exp_cnt++;
        end
        span    = 3 + w + n + 8;
        got_cnt = 0;
        @(negedge clk);
        edge_sel = mode;
        repeat (4) @(negedge clk);
        for (int k = 0; k <= span; k++) begin
            if (k > 0) @(negedge clk);
            if (k > 0 && cap_pulse) begin
                if (got_cnt < 4) got_t[got_cnt] = k;
                got_cnt++;
            end
            if (k == 0) pin_raw = ~start;
            if (w > 0 && k == w) pin_raw = start;
        end
        check(req, got_cnt, exp_cnt, $sformatf("pulse count sel=%0d mode=%0d w=%0d", cur_sel, mode, w));
        if (got_cnt == exp_cnt) begin
            for (int i = 0; i < exp_cnt; i++)
                check(req, got_t[i], exp_t[i], $sformatf("pulse cycle %0d", i));
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int n;
        int w;
        int pick;
        logic [1:0] s;
        logic [1:0] m;
        void'($urandom(32'd20240611));
        rst = 1'b1; pin_raw = 1'b0; edge_sel = 2'b00;
        dly_wr_en = 1'b0; dly_wr_data = 2'b00;
        repeat (3) @(negedge clk);
        check("R1", int'(cap_pulse), 0, "pulse in reset");
        rst = 1'b0;
        @(negedge clk);
        check("R1", int'(dly_rd_data), 0, "delay select after reset");
        check("R1", int'(cap_pulse), 0, "pulse after reset");

        // R4: bypass latency, rising only, 1-cycle glitch both ways
        run_trial(2'b01, 0, "R4");
        run_trial(2'b11, 1, "R4");
        // R9 / R3: no edges selected
        run_trial(2'b00, 0, "R9");
        run_trial(2'b00, 2, "R9");
        // R2 / R5: boundary widths at each delay
        write_sel(2'b01);
        run_trial(2'b11, UNIT + 1, "R5");
        run_trial(2'b11, UNIT, "R5");
        run_trial(2'b10, 0, "R3");
        write_sel(2'b10);
        run_trial(2'b01, 0, "R2");
        run_trial(2'b11, 2 * UNIT, "R6");
        write_sel(2'b11);
        run_trial(2'b10, 0, "R2");
        // R7: second event after a finished count gets a full delay
        write_sel(2'b01);
        run_trial(2'b11, UNIT + 40, "R7");

        // R8: a write during a running count cancels it
        begin
            int seen;
            seen = 0;
            @(negedge clk);
            edge_sel = 2'b11;
            repeat (3) @(negedge clk);
            pin_raw = ~pin_raw;
            repeat (100) @(negedge clk);
            dly_wr_en = 1'b1; dly_wr_data = 2'b01;
            @(negedge clk);
            dly_wr_en = 1'b0;
            for (int k = 0; k < 2 * UNIT; k++) begin
                @(negedge clk);
                if (cap_pulse) seen++;
            end
            check("R8", seen, 0, "pulses after aborted count");
        end

        // Constrained random trials
        for (int t = 0; t < 36; t++) begin
            pick = $urandom_range(0, 9);
            s = (pick < 2) ? 2'b00 : (pick < 7) ? 2'b01 : (pick < 9) ? 2'b10 : 2'b11;
            if (s != cur_sel) write_sel(s);
            m = 2'($urandom_range(0, 3));
            n = wait_len(s);
            if (n == 0) begin
                w = $urandom_range(0, 5);
            end else begin
                case ($urandom_range(0, 5))
                    0: w = 0;
                    1: w = n;
                    2: w = n + 1;
                    3: w = $urandom_range(1, n);
                    4: w = n + 1 + $urandom_range(0, n);
                    default: w = n - 1;
                endcase
            end
            run_trial(m, w, (n == 0) ? "R4" : "R5");
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule